// File: doc/BRIEF.md
# Flash Suspend/Resume Command Controller

This block models, cycle by cycle, the command state machine of a parallel NOR flash that lets a host pause a long block erase or word program, do other work, and then continue. Every rising clock edge with `wr_en` high is one bus write cycle. The command is taken from the data byte alone, so the address of the write never matters. The block tracks whether an erase or a program is running or suspended. It keeps a status byte and a read-mode selector, and drives a ready/busy line.

The time an operation takes is modelled by a down-counter, one for erase and one for program. A suspend request does not stop the operation at once. It waits out a fixed latency and then stops at the next checkpoint, which comes every `2**CHK_W` counts. While suspended, the counter holds its value, and a resume continues from that value. While an erase is suspended, the host may run a complete program and afterwards return to the suspended erase. The operation is aborted by any of three events: a device reset pulse, loss of the programming voltage, or a lock on the target block. Each abort leaves a trace in the outputs.

Top module: `flash_susp_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `ready`=1, `status`=0x80, `read_mode`=0 (array) and `loc_indet`=0.
- R2: Writing 0x20 and then 0xD0 starts an erase. `ready` then reads 0 for exactly `ERASE_LEN` cycles. Writing 0x40, 0x10 or 0xE8 and then any byte starts a program, which is busy for exactly `PROG_LEN` cycles. Each setup byte sets `read_mode` to 1 (status). When the operation completes, `status` reads 0x80.
- R3: If an erase setup is followed by any byte other than 0xD0, the block returns to idle and sets status bits 5 and 4.
- R4: Writing 0xB0 while an operation runs sets `ready` again after s cycles, where `SUSP_LAT`+1 ≤ s ≤ `SUSP_LAT`+`2**CHK_W`. A suspended erase reads `status`=0xC0 (bits 7 and 6). A suspended program reads 0x84 (bits 7 and 2).
- R5: Neither the suspend nor the resume write changes `read_mode`.
- R6: Writing 0xD0 while suspended clears the suspend bit and resumes the operation. The counter is frozen while suspended, so the number of busy cycles equals the operation length plus the number of suspensions.
- R7: When no operation is running or suspended, writes of 0xD0 and 0xB0 are ignored.
- R8: During an erase suspend, the following are accepted: 0xFF, 0x70, 0x90 and 0x98 (read modes), 0x50 (clear) and 0xD0 (resume). A program (0x40, 0x10 or 0xE8, then data) is also accepted. It runs for `PROG_LEN` cycles with `status`=0x40 and then returns to the suspended erase (0xC0). Writes of 0x20 and 0xB0 are ignored.
- R9: During a program suspend, the reads, 0x50 and 0xD0 are accepted. Writes of 0x40, 0x10, 0xE8, 0x20 and 0xB0 are ignored.
- R10: In idle or suspended state, `read_mode` is set to 0 by 0xFF (array), 1 by 0x70 (status), 2 by 0x90 (device information) and 3 by 0x98 (query). Any other byte leaves `read_mode` unchanged.
- R11: An abort happens when, with an operation running or suspended, `vpen_ok` is low or `blk_locked` is high at a clock edge. The block then goes idle and sets status bits. Bit 3 is set for voltage loss and bit 1 for a lock. Bit 5 is set if an erase was involved and bit 4 if a program was involved.
- R12: A `dev_rst` pulse clears the status to 0x80 and returns `read_mode` to array. If an operation was running or suspended, it is aborted and `loc_indet` is set. A pulse in idle leaves `loc_indet` at 0.
- R13: Writing 0x50 clears status bits 5, 4, 3 and 1 and clears `loc_indet`.
- R14: If the operation reaches its end while a suspend request is still pending, the operation completes normally and no suspend bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_rst | input | 1 | Device reset pulse; aborts an active operation |
| wr_en | input | 1 | One bus write cycle at this edge |
| wr_data | input | 8 | Command or data byte of the write |
| vpen_ok | input | 1 | Programming voltage present |
| blk_locked | input | 1 | Target block is locked |
| ready | output | 1 | 1 when idle, in setup or suspended; 0 while an operation runs |
| status | output | 8 | Status byte (bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 voltage error, bit 2 program suspended, bit 1 lock error) |
| read_mode | output | 2 | 0 array, 1 status, 2 device information, 3 query |
| loc_indet | output | 1 | Contents of the target location are undefined after a reset abort |

## Verification
If the controller holds a wrong state, the host first sees it in the length of the busy window. An operation counter that keeps running while suspended, or restarts on resume, changes the total busy time by many cycles, and the bench measures that time to the exact cycle. A command accepted in the wrong suspend kind shows at the next sample point, as a changed status byte or a wrong ready level. A mistake in the suspend latency or checkpoint logic moves the rising edge of `ready` outside its bounded window within a few cycles of the 0xB0 write.

// File: rtl/flsr_pkg.sv
// Package: command, state and read-mode types for the flash suspend/resume
// controller. Assumes commands are decoded from the data byte alone.
package flsr_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_DEVID  = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    typedef enum logic [3:0] {
        C_NONE, C_RD_ARRAY, C_RD_STATUS, C_CLR_STATUS, C_RD_ID, C_QUERY,
        C_PROG, C_BUF_PROG, C_ERASE, C_SUSPEND, C_CONFIRM
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_ESETUP, S_PSETUP, S_ERUN, S_PRUN,
        S_ESUSP, S_PSUSP, S_NSETUP, S_NRUN
    } st_t;

    // Read mode selected by a read-type command; other commands keep prev.
    function automatic rmode_t rmode_for(cmd_t c, rmode_t prev);
        case (c)
            C_RD_ARRAY:  return RM_ARRAY;
            C_RD_STATUS: return RM_STATUS;
            C_RD_ID:     return RM_DEVID;
            C_QUERY:     return RM_QUERY;
            default:     return prev;
        endcase
    endfunction

endpackage

// File: rtl/flsr_cmd_decode.sv
// Command decoder: maps a bus data byte to a command code.
// Assumes the address of the write is irrelevant to every command.
module flsr_cmd_decode
    import flsr_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       cmd
);

    // Purpose: pure byte-to-command lookup.
    always_comb begin
        case (code)
            8'hFF:        cmd = C_RD_ARRAY;
            8'h70:        cmd = C_RD_STATUS;
            8'h50:        cmd = C_CLR_STATUS;
            8'h90:        cmd = C_RD_ID;
            8'h98:        cmd = C_QUERY;
            8'h40, 8'h10: cmd = C_PROG;
            8'hE8:        cmd = C_BUF_PROG;
            8'h20:        cmd = C_ERASE;
            8'hB0:        cmd = C_SUSPEND;
            8'hD0:        cmd = C_CONFIRM;
            default:      cmd = C_NONE;
        endcase
    end

endmodule

// File: rtl/flsr_op_timer.sv
// Operation timer: down-counter standing in for erase/program duration.
// Assumes LEN >= 2 and CNT_W > CHK_W; 'last' flags the final running cycle,
// 'ckpt' flags a suspend checkpoint (low CHK_W bits zero).
module flsr_op_timer #(
    parameter int LEN   = 200,
    parameter int CNT_W = 8,
    parameter int CHK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             ckpt
);

    // Purpose: load the length on start, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= CNT_W'(LEN);
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Purpose: derive the end and checkpoint flags from the count.
    always_comb begin
        last = (cnt == CNT_W'(1));
        ckpt = (cnt[CHK_W-1:0] == '0);
    end

    // R6: with neither load nor run the count must hold (frozen on suspend)
    a_r6_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/flsr_susp_gate.sv
// Suspend gate: holds a pending suspend request and times the minimum
// latency before it may take effect. Assumes LAT >= 1 and that arm and
// clear are never high together.
module flsr_susp_gate #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    output logic pending,
    output logic elapsed
);

    localparam int LAT_W = $clog2(LAT + 1);

    logic [LAT_W-1:0] lat;

    // Purpose: track the request and count its latency down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            lat     <= '0;
        end else if (arm) begin
            pending <= 1'b1;
            lat     <= LAT_W'(LAT);
        end else if (clear) begin
            pending <= 1'b0;
        end else if (pending && lat != '0) begin
            lat <= lat - 1'b1;
        end
    end

    // Purpose: the request may act once the latency has run out.
    assign elapsed = pending && (lat == '0);

    // R4: a fresh request can never act on the following cycle
    a_r4_latency_floor: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (pending && !elapsed));

endmodule

// File: rtl/flash_susp_ctrl.sv
// Flash suspend/resume command controller (top).
// Decodes bus writes, runs erase/program through two duration timers,
// handles suspend at checkpoints after a latency, filters commands while
// suspended, and aborts on device reset, voltage loss or block lock.
// Assumes wr_en is a single-cycle write strobe synchronous to clk.
module flash_susp_ctrl
    import flsr_pkg::*;
#(
    parameter int ERASE_LEN = 200,
    parameter int PROG_LEN  = 40,
    parameter int SUSP_LAT  = 3,
    parameter int CHK_W     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       vpen_ok,
    input  logic       blk_locked,
    output logic       ready,
    output logic [7:0] status,
    output logic [1:0] read_mode,
    output logic       loc_indet
);

    localparam int EW = $clog2(ERASE_LEN + 1);
    localparam int PW = $clog2(PROG_LEN + 1);

    st_t     st, st_nx;
    rmode_t  rmode, rm_nx;
    cmd_t    cmd;
    logic    err_e, err_p, err_v, err_l;
    logic    clr_req, seq_err;
    logic    active, cmd_window;
    logic    e_take, p_take, e_run, p_run, e_load, p_load;
    logic    e_last, p_last, e_ckpt, p_ckpt;
    logic    s_arm, s_clear, s_pend, s_elapsed;
    logic [EW-1:0] e_cnt;
    logic [PW-1:0] p_cnt;

    flsr_cmd_decode u_dec (.code(wr_data), .cmd(cmd));

    flsr_op_timer #(.LEN(ERASE_LEN), .CNT_W(EW), .CHK_W(CHK_W)) u_etmr (
        .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run),
        .cnt(e_cnt), .last(e_last), .ckpt(e_ckpt));

    flsr_op_timer #(.LEN(PROG_LEN), .CNT_W(PW), .CHK_W(CHK_W)) u_ptmr (
        .clk(clk), .rst_n(rst_n), .load(p_load), .run(p_run),
        .cnt(p_cnt), .last(p_last), .ckpt(p_ckpt));

    flsr_susp_gate #(.LAT(SUSP_LAT)) u_gate (
        .clk(clk), .rst_n(rst_n), .arm(s_arm), .clear(s_clear),
        .pending(s_pend), .elapsed(s_elapsed));

    // Purpose: qualifiers shared by the timers, the gate and the FSM.
    always_comb begin
        active     = st inside {S_ERUN, S_PRUN, S_ESUSP, S_PSUSP, S_NRUN};
        cmd_window = st inside {S_IDLE, S_ESUSP, S_PSUSP};
        e_take     = (st == S_ERUN) && s_elapsed && e_ckpt && !e_last;
        p_take     = (st == S_PRUN) && s_elapsed && p_ckpt && !p_last;
        e_run      = (st == S_ERUN) && !e_take;
        p_run      = ((st == S_PRUN) && !p_take) || (st == S_NRUN);
        e_load     = (st == S_ESETUP) && wr_en && (cmd == C_CONFIRM);
        p_load     = (st inside {S_PSETUP, S_NSETUP}) && wr_en;
        s_arm      = (st inside {S_ERUN, S_PRUN}) && wr_en && (cmd == C_SUSPEND) && !s_pend;
        s_clear    = !(st inside {S_ERUN, S_PRUN});
    end

    // Purpose: next state, read mode and command side effects.
    always_comb begin
        st_nx   = st;
        rm_nx   = rmode;
        clr_req = 1'b0;
        seq_err = 1'b0;
        if (wr_en && cmd_window) begin
            rm_nx   = rmode_for(cmd, rmode);
            clr_req = (cmd == C_CLR_STATUS);
        end
        case (st)
            S_IDLE: if (wr_en) begin
                if (cmd inside {C_PROG, C_BUF_PROG}) begin
                    st_nx = S_PSETUP; rm_nx = RM_STATUS;
                end else if (cmd == C_ERASE) begin
                    st_nx = S_ESETUP; rm_nx = RM_STATUS;
                end
            end
            S_ESETUP: if (wr_en) begin
                if (cmd == C_CONFIRM) st_nx = S_ERUN;
                else begin st_nx = S_IDLE; seq_err = 1'b1; end
            end
            S_PSETUP: if (wr_en) st_nx = S_PRUN;
            S_NSETUP: if (wr_en) st_nx = S_NRUN;
            S_ERUN: begin
                if (e_last)      st_nx = S_IDLE;
                else if (e_take) st_nx = S_ESUSP;
            end
            S_PRUN: begin
                if (p_last)      st_nx = S_IDLE;
                else if (p_take) st_nx = S_PSUSP;
            end
            S_NRUN: if (p_last) st_nx = S_ESUSP;
            S_ESUSP: if (wr_en) begin
                if (cmd inside {C_PROG, C_BUF_PROG}) begin
                    st_nx = S_NSETUP; rm_nx = RM_STATUS;
                end else if (cmd == C_CONFIRM) st_nx = S_ERUN;
            end
            S_PSUSP: if (wr_en && cmd == C_CONFIRM) st_nx = S_PRUN;
            default: st_nx = S_IDLE;
        endcase
    end

    // Purpose: state, read mode, error flags and indeterminate marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; rmode <= RM_ARRAY;
            err_e <= 1'b0; err_p <= 1'b0; err_v <= 1'b0; err_l <= 1'b0;
            loc_indet <= 1'b0;
        end else if (dev_rst) begin
            st <= S_IDLE; rmode <= RM_ARRAY;
            err_e <= 1'b0; err_p <= 1'b0; err_v <= 1'b0; err_l <= 1'b0;
            if (active) loc_indet <= 1'b1;
        end else if (active && (!vpen_ok || blk_locked)) begin
            st <= S_IDLE;
            if (!vpen_ok)   err_v <= 1'b1;
            if (blk_locked) err_l <= 1'b1;
            if (st inside {S_ERUN, S_ESUSP, S_NRUN}) err_e <= 1'b1;
            if (st inside {S_PRUN, S_PSUSP, S_NRUN}) err_p <= 1'b1;
        end else begin
            st    <= st_nx;
            rmode <= rm_nx;
            if (clr_req) begin
                err_e <= 1'b0; err_p <= 1'b0; err_v <= 1'b0; err_l <= 1'b0;
                loc_indet <= 1'b0;
            end else if (seq_err) begin
                err_e <= 1'b1; err_p <= 1'b1;
            end
        end
    end

    // Purpose: drive ready, status byte and read mode from state and flags.
    always_comb begin
        ready     = !(st inside {S_ERUN, S_PRUN, S_NRUN});
        status    = {ready, (st inside {S_ESUSP, S_NSETUP, S_NRUN}), err_e, err_p,
                     err_v, (st == S_PSUSP), err_l, 1'b0};
        read_mode = rmode;
    end

    // R6: erase count frozen while the erase is suspended
    a_r6_erase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ESUSP) |=> $stable(e_cnt));
    // R6: program count frozen while the program is suspended
    a_r6_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PSUSP) |=> $stable(p_cnt));
    // R2: busy always has remaining work in one of the timers
    a_r2_busy_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (e_cnt != '0 || p_cnt != '0));
    // R7: resume in idle leaves the controller idle
    a_r7_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && wr_en && wr_data == 8'hD0 && !dev_rst) |=> (st == S_IDLE));
    // R12: device reset returns ready, array mode and a clean status
    a_r12_dev_reset: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (ready && read_mode == 2'd0 && status == 8'h80));
    // R11: voltage loss on an active operation aborts with bit 3
    a_r11_vpen_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !vpen_ok && !dev_rst) |=> (ready && status[3]));

endmodule

// File: tb/tb_flash_susp_ctrl.sv
module tb_flash_susp_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ERASE_LEN  = 200;
    localparam int PROG_LEN   = 40;
    localparam int SUSP_LAT   = 3;
    localparam int CHK_W      = 3;

    logic       clk = 1'b0;
    logic       rst_n, dev_rst, wr_en, vpen_ok, blk_locked;
    logic [7:0] wr_data;
    logic       ready, loc_indet;
    logic [7:0] status;
    logic [1:0] read_mode;
    int checks = 0;
    int errors = 0;

    flash_susp_ctrl #(.ERASE_LEN(ERASE_LEN), .PROG_LEN(PROG_LEN),
                      .SUSP_LAT(SUSP_LAT), .CHK_W(CHK_W)) dut (
        .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .wr_en(wr_en),
        .wr_data(wr_data), .vpen_ok(vpen_ok), .blk_locked(blk_locked),
        .ready(ready), .status(status), .read_mode(read_mode), .loc_indet(loc_indet));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_mode(logic [7:0] c, int prev);
        case (c)
            8'hFF: return 0;
            8'h70: return 1;
            8'h90: return 2;
            8'h98: return 3;
            default: return prev;
        endcase
    endfunction

    function automatic int exp_susp(bit is_erase);
        return is_erase ? 32'hC0 : 32'h84;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(string req, string what, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, s, n2, k, m;
        bit is_e;
        logic [7:0] c;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; dev_rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        vpen_ok = 1'b1; blk_locked = 1'b0;
        idle(3);
        // R1 reset state
        chk("R1", "ready", ready, 1);
        chk("R1", "status", status, 8'h80);
        chk("R1", "read_mode", read_mode, 0);
        chk("R1", "loc_indet", loc_indet, 0);
        rst_n = 1'b1;
        idle(1);

        // R10 read-mode codes
        wr(8'h90); chk("R10", "mode after 90", read_mode, 2);
        wr(8'h98); chk("R10", "mode after 98", read_mode, 3);
        wr(8'hFF); chk("R10", "mode after FF", read_mode, 0);
        wr(8'h70); chk("R10", "mode after 70", read_mode, 1);

        // R7 resume and suspend ignored in idle
        wr(8'hD0); chk("R7", "status after idle D0", status, 8'h80);
        chk("R7", "ready after idle D0", ready, 1);
        wr(8'hB0); chk("R7", "status after idle B0", status, 8'h80);
        chk("R7", "mode after idle B0", read_mode, 1);

        // R2 erase duration and read mode
        wr(8'hFF); wr(8'h20);
        chk("R2", "mode after erase setup", read_mode, 1);
        wr(8'hD0); chk("R2", "busy after confirm", ready, 0);
        wait_ready(n); chk("R2", "erase busy cycles", n, ERASE_LEN);
        chk("R2", "status after erase", status, 8'h80);
        // R2 program duration
        wr(8'hFF); wr(8'h40); wr(8'h5A);
        wait_ready(n); chk("R2", "program busy cycles", n, PROG_LEN);
        chk("R2", "status after program", status, 8'h80);

        // R3 bad erase confirm, R13 clear
        wr(8'h20); wr(8'hFF);
        chk("R3", "status after bad confirm", status, 8'hB0);
        chk("R3", "ready after bad confirm", ready, 1);
        wr(8'h50); chk("R13", "status after clear", status, 8'h80);

        // R4 R5 R6 R8 erase suspend with nested program
        wr(8'h20); wr(8'hD0); idle(5); wr(8'hB0);
        wait_ready(s);
        chk_rng("R4", "erase suspend latency", s, SUSP_LAT + 1, SUSP_LAT + (1 << CHK_W));
        chk("R4", "erase suspend status", status, 8'hC0);
        chk("R5", "mode kept on suspend", read_mode, 1);
        wr(8'h20); chk("R8", "erase rejected in erase suspend", status, 8'hC0);
        wr(8'hB0); chk("R8", "suspend rejected in erase suspend", status, 8'hC0);
        chk("R8", "ready after rejects", ready, 1);
        wr(8'h40); chk("R8", "program setup accepted", status, 8'hC0);
        wr(8'h33); chk("R8", "nested program status", status, 8'h40);
        wait_ready(n); chk("R8", "nested program cycles", n, PROG_LEN);
        chk("R8", "back to erase suspend", status, 8'hC0);
        wr(8'hFF); chk("R8", "read array in erase suspend", read_mode, 0);
        wr(8'hD0); chk("R6", "resume clears suspend bit", status, 8'h00);
        chk("R5", "mode kept on resume", read_mode, 0);
        wait_ready(n2);
        chk("R6", "erase total busy", 5 + 1 + s + n2, ERASE_LEN + 1);
        chk("R6", "status after resumed erase", status, 8'h80);

        // R4 R9 program suspend filtering
        wr(8'h40); wr(8'h11); idle(3); wr(8'hB0);
        wait_ready(s);
        chk_rng("R4", "program suspend latency", s, SUSP_LAT + 1, SUSP_LAT + (1 << CHK_W));
        chk("R4", "program suspend status", status, 8'h84);
        wr(8'h40); chk("R9", "40 rejected", status, 8'h84);
        wr(8'hE8); chk("R9", "E8 rejected", status, 8'h84);
        wr(8'h10); chk("R9", "10 rejected", status, 8'h84);
        wr(8'h20); chk("R9", "20 rejected", status, 8'h84);
        wr(8'hB0); chk("R9", "B0 rejected", status, 8'h84);
        wr(8'h90); chk("R9", "read id accepted", read_mode, 2);
        wr(8'hD0); wait_ready(n2);
        chk("R6", "program total busy", 3 + 1 + s + n2, PROG_LEN + 1);

        // R14 suspend request overtaken by completion
        wr(8'h40); wr(8'h00); idle(PROG_LEN - 3); wr(8'hB0);
        wait_ready(s);
        chk("R14", "busy without suspension", (PROG_LEN - 3) + 1 + s, PROG_LEN);
        chk("R14", "no suspend bits", status, 8'h80);

        // R11 aborts: voltage while erase suspended, lock while program suspended
        wr(8'h20); wr(8'hD0); idle(4); wr(8'hB0); wait_ready(s);
        vpen_ok = 1'b0; idle(1); vpen_ok = 1'b1;
        chk("R11", "voltage abort on erase suspend", status, 8'hA8);
        wr(8'h50); chk("R13", "clear after voltage abort", status, 8'h80);
        wr(8'h40); wr(8'h01); idle(4); wr(8'hB0); wait_ready(s);
        blk_locked = 1'b1; idle(1); blk_locked = 1'b0;
        chk("R11", "lock abort on program suspend", status, 8'h92);
        wr(8'h50);
        wr(8'h40); wr(8'h02); idle(6);
        vpen_ok = 1'b0; idle(1); vpen_ok = 1'b1;
        chk("R11", "voltage abort on running program", status, 8'h98);
        chk("R11", "ready after abort", ready, 1);
        wr(8'h50);

        // R12 device reset
        wr(8'h20); wr(8'hD0); idle(10);
        dev_rst = 1'b1; idle(1); dev_rst = 1'b0;
        chk("R12", "ready after device reset", ready, 1);
        chk("R12", "status after device reset", status, 8'h80);
        chk("R12", "mode after device reset", read_mode, 0);
        chk("R12", "indeterminate flag", loc_indet, 1);
        wr(8'h50); chk("R13", "indeterminate cleared", loc_indet, 0);
        dev_rst = 1'b1; idle(1); dev_rst = 1'b0;
        chk("R12", "idle device reset leaves flag", loc_indet, 0);

        // Random suspend/resume rounds (R4 R6 R8 R9 R10)
        for (int it = 0; it < 24; it++) begin
            is_e = 1'($urandom % 2);
            if (is_e) begin
                wr(8'h20); wr(8'hD0);
            end else begin
                case ($urandom % 3)
                    0: wr(8'h40);
                    1: wr(8'h10);
                    default: wr(8'hE8);
                endcase
                wr(8'($urandom));
            end
            k = int'($urandom % 12);
            idle(k); wr(8'hB0); wait_ready(s);
            chk_rng("R4", "random suspend latency", s, SUSP_LAT + 1, SUSP_LAT + (1 << CHK_W));
            chk("R4", "random suspend status", status, exp_susp(is_e));
            m = int'(read_mode);
            case ($urandom % (is_e ? 7 : 10))
                0: c = 8'hFF; 1: c = 8'h70; 2: c = 8'h90; 3: c = 8'h98;
                4: c = 8'h20; 5: c = 8'hB0; 6: c = 8'h50;
                7: c = 8'h40; 8: c = 8'h10; default: c = 8'hE8;
            endcase
            wr(c);
            chk("R10", "random mode in suspend", read_mode, exp_mode(c, m));
            chk(is_e ? "R8" : "R9", "random filter status", status, exp_susp(is_e));
            wr(8'hD0); wait_ready(n2);
            chk("R6", "random total busy", k + 1 + s + n2, (is_e ? ERASE_LEN : PROG_LEN) + 1);
            chk("R6", "random final status", status, 8'h80);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule